// File: doc/BRIEF.md
# Dual-Address Dual-Port Synchronous RAM

A single storage array shared by two fully independent ports, X and Y. Each port carries its own address, write data, active-low write strobe and active-low forward control. A pair of shared chip enables, one active-low and one active-high, qualifies every cycle. All of these inputs are captured on the rising clock edge. One cycle later the array is accessed and each port's output register is loaded. The bidirectional data pins of a physical part appear here as a read-data bus plus a drive indication per port. That indication is gated without a clock by the port's active-low output enable.

A port's output register takes one of three values. If the other port asks to forward, it takes the other port's captured write data. Otherwise it takes the stored word for a read. On a write or a deselect it is marked not valid. Collisions on the same address follow fixed rules. Reads see the contents held before any write of the same cycle. When both ports write one address, port Y's data is kept. After reset the first captured cycle is discarded as a warm-up cycle.

The default organisation is 36-bit words behind a 10-bit address. The full-size arrangement is 32768 words, with a 15-bit address per port. Depth and width are parameters, so the block can be simulated small.

Top module: `dualaddr_sram`

## Requirements
- R1: While reset is held and after it is released, neither drive output is asserted until a valid read or forward has passed through the output register.
- R2: The command captured on the first clock edge after reset is released is discarded: it writes nothing, and two edges later neither port's drive is asserted.
- R3: A cycle captured with ce_n high or ce_hi low writes nothing and forwards nothing. Two edges later both drive outputs are low.
- R4: A port whose write strobe is captured low stores its captured write data at its captured address.
- R5: A port captured with its write strobe high, and with the other port not forwarding, shows the stored word of its address. This appears on rdata with drive high (output enable low) after the second rising edge from the command.
- R6: x_fwd_n captured low makes port Y's output carry X's captured write data with the same latency as a read. This overrides Y's own read or write outcome.
- R7: y_fwd_n captured low makes port X's output carry Y's captured write data with the same latency. This overrides X's own read or write outcome.
- R8: Two reads of the same address in one cycle both return the stored word.
- R9: When one port writes and the other reads the same address in one cycle, the reader receives the word held before the write.
- R10: When both ports write the same address in one cycle, the word kept is port Y's data.
- R11: A port's drive output is asserted only while its output enable is low. It follows that enable within the same clock phase, without waiting for an edge.
- R12: A port that writes, and receives no forwarded data, has its drive low for the cycle after the write is applied.
- R13: Writes on both ports, forwards in both directions, and a write on one port with a read on the other may all be combined in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Shared chip enable, active low |
| ce_hi | input | 1 | Shared chip enable, active high |
| x_addr | input | AW | Port X address |
| x_wdata | input | DW | Port X write data |
| x_we_n | input | 1 | Port X write strobe, active low |
| x_fwd_n | input | 1 | Forward X write data to port Y output, active low |
| x_oe_n | input | 1 | Port X output enable, active low, unclocked |
| x_rdata | output | DW | Port X output register |
| x_drive | output | 1 | Port X output valid and enabled |
| y_addr | input | AW | Port Y address |
| y_wdata | input | DW | Port Y write data |
| y_we_n | input | 1 | Port Y write strobe, active low |
| y_fwd_n | input | 1 | Forward Y write data to port X output, active low |
| y_oe_n | input | 1 | Port Y output enable, active low, unclocked |
| y_rdata | output | DW | Port Y output register |
| y_drive | output | 1 | Port Y output valid and enabled |

## Verification
The bench builds the block with AW = 4 and DW = 12, which gives a 16-word array. At that size it can fill every word and read all of them back within a few dozen cycles. It can also aim both ports at the same address whenever it likes, to exercise the read-before-write and Y-wins collision rules. The 12-bit width still keeps the forwarded data distinct from every stored pattern, so a forward that wrongly yields to a read shows up as a data mismatch.

// File: rtl/dasr_pkg.sv
`timescale 1ns/1ps
// dasr_pkg: shared definitions for the dual-address RAM.
// Assumes port index 0 is X and 1 is Y throughout the design.
package dasr_pkg;
    localparam int NPORT = 2;
    localparam int PX    = 0;
    localparam int PY    = 1;

    // Source selected for a port's output register on a given edge.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ARRAY = 2'd1,
        SRC_PASS  = 2'd2
    } out_src_e;
endpackage

// File: rtl/dasr_port_in.sv
`timescale 1ns/1ps
// dasr_port_in: input capture stage for one port.
// Registers address, data and the (inverted, active-high) strobes.
// Assumes a synchronous active-low reset; only the strobes are reset.
module dasr_port_in #(
    parameter int AW = 10,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          we_n_i,
    input  logic          fwd_n_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          we_o,
    output logic          fwd_o
);
    // Capture the strobes, clearing them in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_o  <= 1'b0;
            fwd_o <= 1'b0;
        end else begin
            we_o  <= ~we_n_i;
            fwd_o <= ~fwd_n_i;
        end
    end

    // Capture address and data every edge; no reset needed.
    always_ff @(posedge clk) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
    end
endmodule

// File: rtl/dasr_array.sv
`timescale 1ns/1ps
// dasr_array: storage with two write ports and two combinational reads.
// Reads return the contents before this edge's writes (read-before-write).
// When both ports write one address, port Y's data is kept.
// Assumes contents are undefined until written; no reset of storage.
module dasr_array #(
    parameter int AW = 10,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          x_we,
    input  logic [AW-1:0] x_addr,
    input  logic [DW-1:0] x_wdata,
    input  logic          y_we,
    input  logic [AW-1:0] y_addr,
    input  logic [DW-1:0] y_wdata,
    output logic [DW-1:0] x_rdata,
    output logic [DW-1:0] y_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          same_addr;
    logic          x_we_eff;

    // Drop X's write when Y writes the same word in the same cycle.
    always_comb begin
        same_addr = (x_addr == y_addr);
        x_we_eff  = x_we && !(y_we && same_addr);
    end

    // Apply both writes on the edge.
    always_ff @(posedge clk) begin
        if (x_we_eff) mem[x_addr] <= x_wdata;
        if (y_we)     mem[y_addr] <= y_wdata;
    end

    // Present pre-write contents to both readers.
    always_comb begin
        x_rdata = mem[x_addr];
        y_rdata = mem[y_addr];
    end
endmodule

// File: rtl/dasr_out_stage.sv
`timescale 1ns/1ps
// dasr_out_stage: output register and drive gating for one port.
// Loads array data or forwarded data per the selected source; a NONE
// source clears the valid flag. Drive is gated by the unclocked enable.
module dasr_out_stage #(
    parameter int DW = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dasr_pkg::out_src_e src_i,
    input  logic [DW-1:0]     arr_i,
    input  logic [DW-1:0]     pass_i,
    input  logic              oe_n_i,
    output logic [DW-1:0]     data_o,
    output logic              drive_o
);
    import dasr_pkg::*;

    logic vld_q;

    // Load the output register from the chosen source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            vld_q  <= 1'b0;
        end else begin
            case (src_i)
                SRC_ARRAY: begin
                    data_o <= arr_i;
                    vld_q  <= 1'b1;
                end
                SRC_PASS: begin
                    data_o <= pass_i;
                    vld_q  <= 1'b1;
                end
                default: begin
                    data_o <= data_o;
                    vld_q  <= 1'b0;
                end
            endcase
        end
    end

    // Drive only while valid and the enable is low.
    always_comb begin
        drive_o = vld_q & ~oe_n_i;
    end
endmodule

// File: rtl/dualaddr_sram.sv
`timescale 1ns/1ps
// dualaddr_sram: two-port, two-address synchronous RAM with forwarding.
// Edge 1 captures the command; edge 2 writes the array and loads outputs.
// The first captured cycle after reset is discarded (warm-up).
// Assumes synchronous active-low reset and a single clock.
module dualaddr_sram #(
    parameter int AW = 10,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          ce_hi,
    input  logic [AW-1:0] x_addr,
    input  logic [DW-1:0] x_wdata,
    input  logic          x_we_n,
    input  logic          x_fwd_n,
    input  logic          x_oe_n,
    output logic [DW-1:0] x_rdata,
    output logic          x_drive,
    input  logic [AW-1:0] y_addr,
    input  logic [DW-1:0] y_wdata,
    input  logic          y_we_n,
    input  logic          y_fwd_n,
    input  logic          y_oe_n,
    output logic [DW-1:0] y_rdata,
    output logic          y_drive
);
    import dasr_pkg::*;

    logic [NPORT-1:0][AW-1:0] addr_in, addr_q;
    logic [NPORT-1:0][DW-1:0] wdata_in, wdata_q, arr_rd, rdata_out;
    logic [NPORT-1:0]         we_n_in, fwd_n_in, oe_n_in;
    logic [NPORT-1:0]         we_q, fwd_q, wr_en, pass_en, drive_out;
    out_src_e                 src [NPORT];
    logic                     warm_q;
    logic                     sel_q;

    // Gather the per-port pins into indexed vectors.
    always_comb begin
        addr_in[PX]  = x_addr;   addr_in[PY]  = y_addr;
        wdata_in[PX] = x_wdata;  wdata_in[PY] = y_wdata;
        we_n_in[PX]  = x_we_n;   we_n_in[PY]  = y_we_n;
        fwd_n_in[PX] = x_fwd_n;  fwd_n_in[PY] = y_fwd_n;
        oe_n_in[PX]  = x_oe_n;   oe_n_in[PY]  = y_oe_n;
    end

    // Capture chip select, blocking it during the warm-up cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= 1'b1;
            sel_q  <= 1'b0;
        end else begin
            warm_q <= 1'b0;
            sel_q  <= (!ce_n && ce_hi) && !warm_q;
        end
    end

    genvar p;
    generate
        for (p = 0; p < NPORT; p++) begin : g_port
            localparam int OTHER = NPORT - 1 - p;

            dasr_port_in #(.AW(AW), .DW(DW)) u_in (
                .clk    (clk),
                .rst_n  (rst_n),
                .addr_i (addr_in[p]),
                .wdata_i(wdata_in[p]),
                .we_n_i (we_n_in[p]),
                .fwd_n_i(fwd_n_in[p]),
                .addr_o (addr_q[p]),
                .wdata_o(wdata_q[p]),
                .we_o   (we_q[p]),
                .fwd_o  (fwd_q[p])
            );

            // Qualify the captured strobes with the chip select.
            always_comb begin
                wr_en[p]   = sel_q & we_q[p];
                pass_en[p] = sel_q & fwd_q[p];
            end

            // Pick the output source: forward beats read; write shows nothing.
            always_comb begin
                if (pass_en[OTHER])
                    src[p] = SRC_PASS;
                else if (sel_q && !we_q[p])
                    src[p] = SRC_ARRAY;
                else
                    src[p] = SRC_NONE;
            end

            dasr_out_stage #(.DW(DW)) u_out (
                .clk    (clk),
                .rst_n  (rst_n),
                .src_i  (src[p]),
                .arr_i  (arr_rd[p]),
                .pass_i (wdata_q[OTHER]),
                .oe_n_i (oe_n_in[p]),
                .data_o (rdata_out[p]),
                .drive_o(drive_out[p])
            );
        end
    endgenerate

    dasr_array #(.AW(AW), .DW(DW)) u_array (
        .clk    (clk),
        .x_we   (wr_en[PX]),
        .x_addr (addr_q[PX]),
        .x_wdata(wdata_q[PX]),
        .y_we   (wr_en[PY]),
        .y_addr (addr_q[PY]),
        .y_wdata(wdata_q[PY]),
        .x_rdata(arr_rd[PX]),
        .y_rdata(arr_rd[PY])
    );

    // Return the indexed outputs to the named pins.
    always_comb begin
        x_rdata = rdata_out[PX];
        y_rdata = rdata_out[PY];
        x_drive = drive_out[PX];
        y_drive = drive_out[PY];
    end
endmodule

// File: rtl/dasr_checker.sv
`timescale 1ns/1ps
// dasr_checker: temporal properties of dualaddr_sram, observed at its pins.
// Keeps its own warm-up tracker rather than reading design state.
module dasr_checker #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          ce_hi,
    input logic          x_we_n,
    input logic          x_fwd_n,
    input logic          y_we_n,
    input logic          y_fwd_n,
    input logic [DW-1:0] x_wdata,
    input logic [DW-1:0] y_wdata,
    input logic [DW-1:0] x_rdata,
    input logic [DW-1:0] y_rdata,
    input logic          x_drive,
    input logic          y_drive
);
    logic armed_q;
    logic live;

    // Track whether one edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    always_comb live = armed_q && !ce_n && ce_hi;

    // R1: the edge after a reset edge leaves both drives low.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!x_drive && !y_drive));

    // R2: the warm-up capture yields no output.
    assert_warmup_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |=> ##1 (!x_drive && !y_drive));

    // R3: a deselected capture yields no output.
    assert_deselect_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || !ce_hi) |=> ##1 (!x_drive && !y_drive));

    // R6: forward X reaches Y's output register.
    assert_fwd_x_to_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !x_fwd_n) |=> ##1 (y_rdata == $past(x_wdata, 2)));

    // R7: forward Y reaches X's output register.
    assert_fwd_y_to_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !y_fwd_n) |=> ##1 (x_rdata == $past(y_wdata, 2)));

    // R12: a write without incoming forward leaves that port undriven.
    assert_write_hides_x_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !x_we_n && y_fwd_n) |=> ##1 !x_drive);

    assert_write_hides_y_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !y_we_n && x_fwd_n) |=> ##1 !y_drive);
endmodule

bind dualaddr_sram dasr_checker #(.DW(DW)) u_dasr_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .ce_hi  (ce_hi),
    .x_we_n (x_we_n),
    .x_fwd_n(x_fwd_n),
    .y_we_n (y_we_n),
    .y_fwd_n(y_fwd_n),
    .x_wdata(x_wdata),
    .y_wdata(y_wdata),
    .x_rdata(x_rdata),
    .y_rdata(y_rdata),
    .x_drive(x_drive),
    .y_drive(y_drive)
);

// File: tb/dualaddr_sram_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: issue() drives one cycle and queues the expected
// outputs of both ports; a negedge monitor compares them when due.
module dualaddr_sram_bench;
    localparam int AW    = 4;
    localparam int DW    = 12;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, ce_hi = 1'b0;
    logic [AW-1:0] x_addr = '0, y_addr = '0;
    logic [DW-1:0] x_wdata = '0, y_wdata = '0;
    logic          x_we_n = 1'b1, y_we_n = 1'b1;
    logic          x_fwd_n = 1'b1, y_fwd_n = 1'b1;
    logic          x_oe_n = 1'b0, y_oe_n = 1'b0;
    logic [DW-1:0] x_rdata, y_rdata;
    logic          x_drive, y_drive;

    always #2.5 clk = ~clk;

    dualaddr_sram #(.AW(AW), .DW(DW)) u_dualaddr_sram (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce_hi(ce_hi),
        .x_addr(x_addr), .x_wdata(x_wdata), .x_we_n(x_we_n), .x_fwd_n(x_fwd_n),
        .x_oe_n(x_oe_n), .x_rdata(x_rdata), .x_drive(x_drive),
        .y_addr(y_addr), .y_wdata(y_wdata), .y_we_n(y_we_n), .y_fwd_n(y_fwd_n),
        .y_oe_n(y_oe_n), .y_rdata(y_rdata), .y_drive(y_drive)
    );

    typedef struct {
        int unsigned   due;
        bit            port;
        bit            valid;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t          sbq[$];
    logic [DW-1:0] model [DEPTH];
    int unsigned   cyc = 0;
    int            n_chk = 0;
    int            n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare queued expectations that fall due this cycle.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            logic drv, oe;
            logic [DW-1:0] dat;
            e   = sbq.pop_front();
            drv = e.port ? y_drive : x_drive;
            oe  = e.port ? y_oe_n : x_oe_n;
            dat = e.port ? y_rdata : x_rdata;
            chk(e.tag, e.port ? "y_drive" : "x_drive",
                DW'(drv), DW'(e.valid && !oe));
            if (e.valid) chk(e.tag, e.port ? "y_rdata" : "x_rdata", dat, e.data);
        end
    end

    // Driver: one command cycle plus its expected outputs.
    task automatic issue(input logic cn, input logic ch,
                         input logic [AW-1:0] xa, input logic [DW-1:0] xd,
                         input logic xwn, input logic xfn,
                         input logic [AW-1:0] ya, input logic [DW-1:0] yd,
                         input logic ywn, input logic yfn,
                         input bit blocked, input string tag);
        exp_t ex, ey;
        bit   act;
        @(negedge clk);
        rst_n = 1'b1;
        ce_n = cn; ce_hi = ch;
        x_addr = xa; x_wdata = xd; x_we_n = xwn; x_fwd_n = xfn;
        y_addr = ya; y_wdata = yd; y_we_n = ywn; y_fwd_n = yfn;
        act = !cn && ch && !blocked;
        ex.due = cyc + 2; ex.port = 1'b0; ex.tag = tag; ex.valid = 1'b0; ex.data = '0;
        ey.due = cyc + 2; ey.port = 1'b1; ey.tag = tag; ey.valid = 1'b0; ey.data = '0;
        if (act) begin
            if (!yfn)      begin ex.valid = 1'b1; ex.data = yd; end
            else if (xwn)  begin ex.valid = 1'b1; ex.data = model[xa]; end
            if (!xfn)      begin ey.valid = 1'b1; ey.data = xd; end
            else if (ywn)  begin ey.valid = 1'b1; ey.data = model[ya]; end
            if (!xwn) model[xa] = xd;
            if (!ywn) model[ya] = yd;
        end
        sbq.push_back(ex);
        sbq.push_back(ey);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            issue(1'b1, 1'b0, '0, '0, 1'b1, 1'b1, '0, '0, 1'b1, 1'b1, 1'b0, "R3");
    endtask

    task automatic rd(input logic [AW-1:0] xa, input logic [AW-1:0] ya, input string tag);
        issue(1'b0, 1'b1, xa, '0, 1'b1, 1'b1, ya, '0, 1'b1, 1'b1, 1'b0, tag);
    endtask

    task automatic hold_reset;
        @(negedge clk);
        rst_n = 1'b0;
        ce_n = 1'b1; ce_hi = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "x_drive in reset", DW'(x_drive), '0);
        chk("R1", "y_drive in reset", DW'(y_drive), '0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        hold_reset();
        // R2: first capture after release is discarded (idle here).
        issue(1'b0, 1'b1, 4'd0, 12'h000, 1'b1, 1'b1, 4'd0, 12'h000, 1'b1, 1'b1, 1'b1, "R2");

        // R4/R12/R13: fill with simultaneous writes on both ports.
        for (int i = 0; i < DEPTH / 2; i++)
            issue(1'b0, 1'b1, AW'(2 * i), DW'(i * 37 + 5), 1'b0, 1'b1,
                  AW'(2 * i + 1), DW'(i * 91 + 300), 1'b0, 1'b1, 1'b0, "R12");

        // R5: reads on both ports at different addresses.
        for (int i = 0; i < DEPTH; i++) rd(AW'(i), AW'(DEPTH - 1 - i), "R5");

        // R8: both ports read one address.
        rd(4'd6, 4'd6, "R8");
        rd(4'd13, 4'd13, "R8");

        // R9: write on one port, read of same address on the other.
        issue(1'b0, 1'b1, 4'd3, 12'hA11, 1'b0, 1'b1, 4'd3, '0, 1'b1, 1'b1, 1'b0, "R9");
        issue(1'b0, 1'b1, 4'd7, '0, 1'b1, 1'b1, 4'd7, 12'hB22, 1'b0, 1'b1, 1'b0, "R9");
        rd(4'd7, 4'd3, "R4");

        // R10: both write one address; Y kept.
        issue(1'b0, 1'b1, 4'd9, 12'h111, 1'b0, 1'b1, 4'd9, 12'h222, 1'b0, 1'b1, 1'b0, "R10");
        rd(4'd9, 4'd9, "R10");

        // R6: X forwards while both read.
        issue(1'b0, 1'b1, 4'd1, 12'h5A5, 1'b1, 1'b0, 4'd2, '0, 1'b1, 1'b1, 1'b0, "R6");
        // R7: Y forwards while X writes and Y reads.
        issue(1'b0, 1'b1, 4'd4, 12'h7E7, 1'b0, 1'b1, 4'd6, 12'h3C3, 1'b1, 1'b0, 1'b0, "R7");
        rd(4'd4, 4'd2, "R4");

        // R13: both write, both forward, same cycle.
        issue(1'b0, 1'b1, 4'd10, 12'h0F0, 1'b0, 1'b0, 4'd11, 12'h00F, 1'b0, 1'b0, 1'b0, "R13");
        rd(4'd11, 4'd10, "R13");
        issue(1'b0, 1'b1, 4'd12, 12'hC0C, 1'b0, 1'b1, 4'd13, '0, 1'b1, 1'b1, 1'b0, "R13");
        rd(4'd12, 4'd12, "R13");

        // R3: deselect by either enable blocks writes and forwards.
        issue(1'b1, 1'b1, 4'd0, 12'hDEA, 1'b0, 1'b0, 4'd5, 12'hDEB, 1'b0, 1'b0, 1'b0, "R3");
        issue(1'b0, 1'b0, 4'd0, 12'hDEC, 1'b0, 1'b0, 4'd5, 12'hDED, 1'b0, 1'b0, 1'b0, "R3");
        rd(4'd0, 4'd5, "R3");

        // R11: output enable gates drive between edges.
        idle(3);
        @(negedge clk);
        x_oe_n = 1'b1;
        rd(4'd5, 4'd8, "R11");
        rd(4'd5, 4'd8, "R11");
        rd(4'd5, 4'd8, "R11");
        @(negedge clk);
        #0.4 x_oe_n = 1'b0;
        #0.4 chk("R11", "x_drive after enable", DW'(x_drive), DW'(1));
        chk("R11", "x_rdata after enable", x_rdata, model[5]);
        #0.4 x_oe_n = 1'b1;
        #0.4 chk("R11", "x_drive after disable", DW'(x_drive), '0);
        x_oe_n = 1'b0;

        // R2: after a second reset, the first capture writes nothing.
        idle(4);
        hold_reset();
        issue(1'b0, 1'b1, 4'd5, 12'hFFF, 1'b0, 1'b0, 4'd5, 12'hEEE, 1'b1, 1'b0, 1'b1, "R2");
        rd(4'd5, 4'd5, "R2");
        idle(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule